// File: doc/BRIEF.md
# Open-Drain Repeater Direction Arbiter

This block holds the digital direction logic of a repeater that joins two open-drain segments (side A and side B) on each of several lines, typically a clock line and a data line. For every line it samples synchronized levels from both sides. It finds out which side an outside device is pulling low, and it turns on the open-drain pull-down on the opposite side. That pull-down stays on for as long as the originating side stays low. A direction lock makes sure that the low the block creates on the far side is never taken for a fresh outside low. If it were, the line would latch low with both pull-downs on.

When a low period ends and both sides read high again, each side receives a fixed-length strobe that drives a rise-time booster. No pull-down is active while a strobe runs. A connect input from the connection controller isolates the two segments completely. A booster enable input suppresses only the strobes. The lines are independent of one another and may repeat in opposite directions at the same time.

Top module: `odbuf_dir_arbiter`

## Requirements
- R1: One cycle after side A of a line reads low while that line is idle and connected, `b_pull` for that line is 1, and it stays 1 for as long as side A reads low.
- R2: Side B is handled the same way: one cycle after side B reads low while the line is idle, `a_pull` is 1, and it stays 1 while side B reads low.
- R3: One cycle after the owning side reads high, the pull-down on the driven side is 0.
- R4: The two pull-downs of one line are never 1 together. While a side owns the line, a low read on the driven side never turns on the pull-down toward the owner.
- R5: If both sides of an idle line read low in the same cycle, side A becomes the owner, so `b_pull`=1 and `a_pull`=0 one cycle later.
- R6: After the owner releases, the first cycle in which both sides read high with `boost_en`=1 sets `a_boost` and `b_boost` to 1 in the following cycle, for exactly PULSE_CYC cycles. No pull-down is active while a strobe is 1. A low read on either side ends the strobes one cycle later, in the same cycle that the new pull-down turns on.
- R7: With `boost_en`=0 no strobe is ever 1, and repeating works as in R1 to R3.
- R8: One cycle after `link_en` reads 0, every pull-down and strobe output is 0, and the line forgets its owner.
- R9: After the owner releases, the direction lock stays until the driven side reads high or BLANK_CYC cycles have passed. If the driven side is still low when the lock expires, that low is repeated back toward the former owner one cycle later.
- R10: Lines operate independently. Two lines may repeat in opposite directions in the same cycle.
- R11: While reset is asserted and in the cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Connect permission from the connection controller; 0 isolates both sides |
| boost_en | input | 1 | Enables the rise-booster strobes |
| a_lvl | input | NCH | Synchronized level of side A per line, 1 = high |
| b_lvl | input | NCH | Synchronized level of side B per line, 1 = high |
| a_pull | output | NCH | Open-drain pull-down enable for side A |
| b_pull | output | NCH | Open-drain pull-down enable for side B |
| a_boost | output | NCH | Rise-booster strobe for side A |
| b_boost | output | NCH | Rise-booster strobe for side B |

## Verification
The booster strobe and a new pull-down can land on the same clock edge. To provoke this, the bench drives a fresh low onto a side while a release strobe is still running. The check passes only if the strobes fall and the opposite pull-down rises in the same sampled cycle, with no cycle in which both are seen. A second collision is a simultaneous low on both sides of an idle line. That case is judged by which pull-down appears, and the check requires that the reverse one never appears.

// File: rtl/odbuf_pkg.sv
package odbuf_pkg;
  typedef enum logic [2:0] {
    LN_IDLE   = 3'd0,
    LN_A_OWN  = 3'd1,
    LN_B_OWN  = 3'd2,
    LN_A_HOLD = 3'd3,
    LN_B_HOLD = 3'd4
  } lane_st_t;
endpackage

// File: rtl/odbuf_dir_fsm.sv
module odbuf_dir_fsm
  import odbuf_pkg::*;
#(
  parameter int BLANK_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic link_en,
  input  logic a_lvl,
  input  logic b_lvl,
  output logic a_pull,
  output logic b_pull,
  output logic rel_fire
);
  localparam int BW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC + 1);

  lane_st_t      st, nxt;
  logic [BW-1:0] blank_cnt;
  logic          in_hold;
  logic          blank_done;

  assign in_hold    = (st == LN_A_HOLD) || (st == LN_B_HOLD);
  assign blank_done = (blank_cnt == BW'(BLANK_CYC - 1));

  // both sides back above release level after an owned low period
  assign rel_fire = link_en && in_hold && a_lvl && b_lvl;

  always_comb begin
    nxt = st;
    case (st)
      LN_IDLE: begin
        if (!a_lvl)      nxt = LN_A_OWN;   // side A wins a tie
        else if (!b_lvl) nxt = LN_B_OWN;
      end
      LN_A_OWN:  if (a_lvl) nxt = LN_A_HOLD;
      LN_B_OWN:  if (b_lvl) nxt = LN_B_HOLD;
      LN_A_HOLD: begin
        if (!a_lvl)                 nxt = LN_A_OWN;
        else if (b_lvl || blank_done) nxt = LN_IDLE;
      end
      LN_B_HOLD: begin
        if (!b_lvl)                 nxt = LN_B_OWN;
        else if (a_lvl || blank_done) nxt = LN_IDLE;
      end
      default: nxt = LN_IDLE;
    endcase
    if (!link_en) nxt = LN_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= LN_IDLE;
      a_pull <= 1'b0;
      b_pull <= 1'b0;
    end else begin
      st     <= nxt;
      a_pull <= (nxt == LN_B_OWN);
      b_pull <= (nxt == LN_A_OWN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !in_hold)  blank_cnt <= '0;
    else if (!blank_done) blank_cnt <= blank_cnt + 1'b1;
  end
endmodule

// File: rtl/odbuf_boost_pulse.sv
module odbuf_boost_pulse #(
  parameter int PULSE_CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic abort,
  output logic strobe
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || abort)  cnt <= '0;
    else if (load)     cnt <= CW'(PULSE_CYC);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign strobe = (cnt != '0);
endmodule

// File: rtl/odbuf_lane.sv
module odbuf_lane #(
  parameter int BLANK_CYC = 16,
  parameter int PULSE_CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic link_en,
  input  logic boost_en,
  input  logic a_lvl,
  input  logic b_lvl,
  output logic a_pull,
  output logic b_pull,
  output logic a_boost,
  output logic b_boost
);
  localparam int NSIDE = 2;

  logic             rel_fire;
  logic             stop_boost;
  logic [NSIDE-1:0] side_strobe;

  odbuf_dir_fsm #(.BLANK_CYC(BLANK_CYC)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .link_en  (link_en),
    .a_lvl    (a_lvl),
    .b_lvl    (b_lvl),
    .a_pull   (a_pull),
    .b_pull   (b_pull),
    .rel_fire (rel_fire)
  );

  // any low, loss of connection or disable ends a running strobe
  assign stop_boost = !link_en || !boost_en || !a_lvl || !b_lvl;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    odbuf_boost_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk    (clk),
      .rst    (rst),
      .load   (rel_fire && boost_en),
      .abort  (stop_boost),
      .strobe (side_strobe[s])
    );
  end

  assign a_boost = side_strobe[0];
  assign b_boost = side_strobe[1];
endmodule

// File: rtl/odbuf_dir_arbiter.sv
module odbuf_dir_arbiter #(
  parameter int NCH       = 2,
  parameter int BLANK_CYC = 16,
  parameter int PULSE_CYC = 30
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           link_en,
  input  logic           boost_en,
  input  logic [NCH-1:0] a_lvl,
  input  logic [NCH-1:0] b_lvl,
  output logic [NCH-1:0] a_pull,
  output logic [NCH-1:0] b_pull,
  output logic [NCH-1:0] a_boost,
  output logic [NCH-1:0] b_boost
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    odbuf_lane #(
      .BLANK_CYC (BLANK_CYC),
      .PULSE_CYC (PULSE_CYC)
    ) u_lane (
      .clk      (clk),
      .rst      (rst),
      .link_en  (link_en),
      .boost_en (boost_en),
      .a_lvl    (a_lvl[ch]),
      .b_lvl    (b_lvl[ch]),
      .a_pull   (a_pull[ch]),
      .b_pull   (b_pull[ch]),
      .a_boost  (a_boost[ch]),
      .b_boost  (b_boost[ch])
    );
  end
endmodule

// File: rtl/odbuf_dir_arbiter_chk.sv
module odbuf_dir_arbiter_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           link_en,
  input logic           boost_en,
  input logic [NCH-1:0] a_lvl,
  input logic [NCH-1:0] b_lvl,
  input logic [NCH-1:0] a_pull,
  input logic [NCH-1:0] b_pull,
  input logic [NCH-1:0] a_boost,
  input logic [NCH-1:0] b_boost
);
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst) (a_pull & b_pull) == '0); // R4
  AST_ISOLATE: assert property (@(posedge clk) disable iff (rst) !link_en |=> (a_pull == '0 && b_pull == '0 && a_boost == '0 && b_boost == '0)); // R8
  AST_BOOST_GATED: assert property (@(posedge clk) disable iff (rst) !boost_en |=> (a_boost == '0 && b_boost == '0)); // R7
  AST_BOOST_NO_PULL: assert property (@(posedge clk) disable iff (rst) ((a_boost | b_boost) & (a_pull | b_pull)) == '0); // R6

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_B_PULL_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(b_pull[i]) |-> $past(!a_lvl[i])); // R1
    AST_A_PULL_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(a_pull[i]) |-> $past(!b_lvl[i])); // R2
    AST_BOOST_ON_RISE: assert property (@(posedge clk) disable iff (rst) $rose(a_boost[i]) |-> $past(a_lvl[i] && b_lvl[i])); // R6
  end
endmodule

bind odbuf_dir_arbiter odbuf_dir_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .link_en  (link_en),
  .boost_en (boost_en),
  .a_lvl    (a_lvl),
  .b_lvl    (b_lvl),
  .a_pull   (a_pull),
  .b_pull   (b_pull),
  .a_boost  (a_boost),
  .b_boost  (b_boost)
);

// File: tb/sim_odbuf_dir_arbiter.sv
module sim_odbuf_dir_arbiter;
  localparam int CLK_P = 10;
  localparam int NCH   = 2;
  localparam int BLANK = 16;
  localparam int PULSE = 30;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           link_en = 1'b1;
  logic           boost_en = 1'b1;
  logic [NCH-1:0] a_lvl = '1;
  logic [NCH-1:0] b_lvl = '1;
  logic [NCH-1:0] a_pull, b_pull, a_boost, b_boost;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  odbuf_dir_arbiter #(.NCH(NCH), .BLANK_CYC(BLANK), .PULSE_CYC(PULSE)) u0 (
    .clk(clk), .rst(rst), .link_en(link_en), .boost_en(boost_en),
    .a_lvl(a_lvl), .b_lvl(b_lvl), .a_pull(a_pull), .b_pull(b_pull),
    .a_boost(a_boost), .b_boost(b_boost)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; tick(3);
    chk("R11", "a_pull in reset", a_pull, 2'b00);
    chk("R11", "b_boost in reset", b_boost, 2'b00);
    rst = 1'b0; tick(1);
    chk("R11", "b_pull after reset", b_pull, 2'b00);
    chk("R11", "a_boost after reset", a_boost, 2'b00);
  endtask

  task automatic t_a_to_b;
    a_lvl[0] = 1'b0; tick(1);
    chk("R1", "b_pull after A low", b_pull, 2'b01);
    chk("R1", "a_pull after A low", a_pull, 2'b00);
    b_lvl[0] = 1'b0; tick(3);   // echo of own pull-down
    chk("R4", "no reverse on echo", a_pull, 2'b00);
    chk("R1", "b_pull held", b_pull, 2'b01);
    a_lvl[0] = 1'b1; tick(1);
    chk("R3", "b_pull released", b_pull, 2'b00);
    tick(2);
    chk("R4", "lock while B rises", a_pull, 2'b00);
    b_lvl[0] = 1'b1; tick(1);
    chk("R6", "a_boost start", a_boost, 2'b01);
    chk("R6", "b_boost start", b_boost, 2'b01);
    tick(PULSE - 1);
    chk("R6", "boost last cycle", a_boost, 2'b01);
    tick(1);
    chk("R6", "boost ended", b_boost, 2'b00);
  endtask

  task automatic t_b_to_a;
    b_lvl[0] = 1'b0; tick(1);
    chk("R2", "a_pull after B low", a_pull, 2'b01);
    chk("R2", "b_pull after B low", b_pull, 2'b00);
    a_lvl[0] = 1'b0; tick(2);
    chk("R4", "no reverse on A echo", b_pull, 2'b00);
    b_lvl[0] = 1'b1; tick(1);
    chk("R3", "a_pull released", a_pull, 2'b00);
    a_lvl[0] = 1'b1; tick(1);
    chk("R6", "boost after B release", b_boost, 2'b01);
    tick(PULSE + 1);
  endtask

  task automatic t_tie;
    a_lvl[0] = 1'b0; b_lvl[0] = 1'b0; tick(1);
    chk("R5", "tie b_pull", b_pull, 2'b01);
    chk("R5", "tie a_pull", a_pull, 2'b00);
    a_lvl[0] = 1'b1; b_lvl[0] = 1'b1; tick(PULSE + 3);
  endtask

  task automatic t_boost_off;
    boost_en = 1'b0;
    a_lvl[0] = 1'b0; tick(1);
    chk("R7", "repeat with boost off", b_pull, 2'b01);
    b_lvl[0] = 1'b0; a_lvl[0] = 1'b1; tick(1);
    chk("R7", "release with boost off", b_pull, 2'b00);
    b_lvl[0] = 1'b1; tick(2);
    chk("R7", "no a_boost", a_boost, 2'b00);
    tick(PULSE);
    chk("R7", "no b_boost", b_boost, 2'b00);
    boost_en = 1'b1; tick(1);
  endtask

  task automatic t_link_off;
    link_en = 1'b0; a_lvl[0] = 1'b0; tick(2);
    chk("R8", "isolated b_pull", b_pull, 2'b00);
    link_en = 1'b1; tick(1);
    chk("R8", "reconnect b_pull", b_pull, 2'b01);
    link_en = 1'b0; tick(1);
    chk("R8", "drop b_pull", b_pull, 2'b00);
    link_en = 1'b1; tick(1);
    a_lvl[0] = 1'b1; tick(2);
    chk("R6", "boost before drop", a_boost, 2'b01);
    link_en = 1'b0; tick(1);
    chk("R8", "boost cut", a_boost, 2'b00);
    link_en = 1'b1; tick(2);
  endtask

  task automatic t_stretch;
    a_lvl[0] = 1'b0; tick(1);
    b_lvl[0] = 1'b0;            // echo plus a device holding B low
    a_lvl[0] = 1'b1; tick(1);
    chk("R3", "stretch release", b_pull, 2'b00);
    tick(BLANK);
    chk("R9", "lock during blank", a_pull, 2'b00);
    tick(1);
    chk("R9", "held low repeated back", a_pull, 2'b01);
    a_lvl[0] = 1'b0; b_lvl[0] = 1'b1; tick(1);
    chk("R3", "reverse released", a_pull, 2'b00);
    a_lvl[0] = 1'b1; tick(PULSE + 3);
  endtask

  task automatic t_indep;
    a_lvl = 2'b10; b_lvl = 2'b01; tick(1);
    chk("R10", "b_pull per line", b_pull, 2'b01);
    chk("R10", "a_pull per line", a_pull, 2'b10);
    a_lvl = 2'b11; b_lvl = 2'b11; tick(PULSE + 3);
  endtask

  task automatic t_cancel;
    a_lvl[0] = 1'b0; tick(1);
    a_lvl[0] = 1'b1; tick(2);
    chk("R6", "boost running", b_boost, 2'b01);
    a_lvl[0] = 1'b0; tick(1);
    chk("R6", "boost cancelled", a_boost, 2'b00);
    chk("R6", "new pull same cycle", b_pull, 2'b01);
    a_lvl[0] = 1'b1; tick(PULSE + 3);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_a_to_b();
    t_b_to_a();
    t_tie();
    t_boost_off();
    t_link_off();
    t_stretch();
    t_indep();
    t_cancel();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule